// File: doc/BRIEF.md
# Serial Memory I2C Slave Controller

This block is the bus-facing half of a byte-addressed serial memory. It watches the two I2C lines through a fast system clock, oversampling each one through a two-stage synchroniser. From them it recovers START, repeated START and STOP conditions and the bit stream. It answers only to a fixed device code and a pair of chip-select straps. It drives SDA as an active-high "pull low" enable, so the pad cell stays open-drain.

The memory behind it holds 2^17 bytes. The top address bit arrives in the slave address byte, and two further bytes carry the rest. Write data is handed byte by byte to a page write buffer and committed when STOP arrives. The storage side reports a busy flag while it programs, and during that time the controller refuses its own address, so masters can poll on the acknowledge. Reads come from an internal address counter and may run on as long as the master acknowledges each byte. A write-protect input can veto a write request at its first data byte.

Top module: `serial_mem_slave`

## Requirements
- R1: A falling SDA while SCL is high starts address reception from any state. A rising SDA while SCL is high returns the block to idle, and `sda_pull` is low on the cycle after the STOP is seen.
- R2: The slave address byte is decoded MSB first as bits [7:4] device code 4'b1010, bits [3:2] compared with `cs_sel[1:0]`, bit [1] memory address bit 16, bit [0] direction (1 read, 0 write). Only an exact code and select match is acknowledged.
- R3: While `mem_busy` is high the slave address byte is not acknowledged, for reads and writes alike.
- R4: In a write, the slave acknowledges both address bytes and every accepted data byte. Each data byte appears for one cycle on `buf_we`/`buf_addr`/`buf_data`, starting at {bit16, high byte, low byte}.
- R5: Within a write, the address steps in its low 8 bits only, so it wraps inside the 256-byte page.
- R6: `wr_commit` pulses for one cycle after a STOP, and only if the transfer wrote at least one data byte.
- R7: `wp_in` is sampled on the falling SCL edge that ends the low-address acknowledge. If it is high, the first data byte is not acknowledged, nothing reaches the buffer port and no commit follows.
- R8: Read data is sent MSB first and changes only after SCL falls. SDA is released for the 9th clock. Another byte follows a master ACK, and a master NoACK ends the transfer.
- R9: The address counter points one past the last byte accessed. In reads it counts across the whole address space and wraps from 0x1FFFF to 0x00000.
- R10: A write header followed by a repeated START and a read header starts reading at the loaded address, without any buffer write or commit.
- R11: `sda_pull` is only ever raised while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_pull | output | 1 | 1 = drive SDA low (open-drain enable) |
| cs_sel | input | 2 | Chip-select straps matched against address bits [3:2] |
| wp_in | input | 1 | Write protect, high blocks writes |
| mem_busy | input | 1 | Storage is programming a committed page |
| buf_we | output | 1 | One-cycle strobe for a byte into the page buffer |
| buf_addr | output | 17 | Address of the buffered byte |
| buf_data | output | 8 | Buffered data byte |
| wr_commit | output | 1 | One-cycle pulse that starts the internal write |
| rd_addr | output | 17 | Current read address (address counter) |
| rd_data | input | 8 | Data at `rd_addr`, valid within two cycles of a change |

## Verification
The bench writes across a page end and then reads the same span back. A design that wrapped reads at the page, or let writes carry into the next page, returns the wrong byte at 0x12400 or 0x12300. It polls during the busy window, and a design that acknowledged there would return data while the array was not ready. It raises write protect before a write, and a controller that sampled at the wrong edge or buffered the byte anyway would show an extra buffer entry or commit. A selective read at 0x1FFFF must return 0x00000 next, and a current-address read must resume where the previous read ended. A dummy write that committed, or a pull asserted while SCL is high, is counted as well.

// File: rtl/smem_pkg.sv
package smem_pkg;

    localparam int ADDR_W = 17;
    localparam int BYTE_W = 8;
    localparam int PAGE_W = 8;
    localparam int HI_W   = ADDR_W - 1 - PAGE_W;
    localparam int CS_W   = 2;
    localparam int CNT_W  = 4;
    localparam int SYNC_STAGES = 2;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WR,
        ST_RD,
        ST_SKIP
    } phase_e;

    typedef struct packed {
        logic [3:0]      code;
        logic [CS_W-1:0] sel;
        logic            top;
        logic            rd;
    } dev_byte_t;

    function automatic addr_t page_next(addr_t a);
        return {a[ADDR_W-1:PAGE_W], a[PAGE_W-1:0] + 1'b1};
    endfunction

    function automatic addr_t linear_next(addr_t a);
        return a + 1'b1;
    endfunction

    function automatic logic dev_hit(dev_byte_t b, logic [CS_W-1:0] cs);
        return (b.code == DEV_CODE) && (b.sel == cs);
    endfunction

endpackage

// File: rtl/smem_line_sync.sv
module smem_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic prv
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prv   <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prv   <= chain[STAGES-1];
        end
    end

    assign lvl = chain[STAGES-1];
endmodule

// File: rtl/smem_bus_cond.sv
module smem_bus_cond (
    input  logic scl_lvl,
    input  logic scl_prv,
    input  logic sda_lvl,
    input  logic sda_prv,
    output logic cond_start,
    output logic cond_stop,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_steady_hi;

    always_comb begin
        scl_steady_hi = scl_lvl & scl_prv;
        cond_start    = scl_steady_hi & sda_prv & ~sda_lvl;
        cond_stop     = scl_steady_hi & ~sda_prv & sda_lvl;
        scl_rise      = scl_lvl & ~scl_prv;
        scl_fall      = ~scl_lvl & scl_prv;
    end
endmodule

// File: rtl/smem_addr_ctr.sv
module smem_addr_ctr
    import smem_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  addr_t load_val,
    input  logic  step_page,
    input  logic  step_lin,
    output addr_t addr
);
    always_ff @(posedge clk) begin
        if (rst)            addr <= '0;
        else if (load)      addr <= load_val;
        else if (step_page) addr <= page_next(addr);
        else if (step_lin)  addr <= linear_next(addr);
    end
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
    import smem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic [CS_W-1:0]   cs_sel,
    input  logic              wp_in,
    input  logic              mem_busy,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [BYTE_W-1:0] buf_data,
    output logic              wr_commit,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data
);
    localparam int NLINES = 2;
    localparam int SCL_IX = 1;
    localparam int SDA_IX = 0;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

    logic [NLINES-1:0] raw_lines, lvl, prv;
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, cond_start, cond_stop;

    assign raw_lines = {scl_in, sda_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        smem_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .din (raw_lines[g]),
            .lvl (lvl[g]),
            .prv (prv[g])
        );
    end

    assign scl_lvl = lvl[SCL_IX];
    assign sda_lvl = lvl[SDA_IX];

    smem_bus_cond u_cond (
        .scl_lvl    (scl_lvl),
        .scl_prv    (prv[SCL_IX]),
        .sda_lvl    (sda_lvl),
        .sda_prv    (prv[SDA_IX]),
        .cond_start (cond_start),
        .cond_stop  (cond_stop),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall)
    );

    phase_e           st;
    byte_t            shreg, txb;
    logic [HI_W-1:0]  hi_q;
    logic             a16_q;
    logic [CNT_W-1:0] bitcnt;
    logic             wp_lat, have_data, mack;
    logic             ctr_load, ctr_step_page, ctr_step_lin;
    addr_t            ctr_val, cur_addr;
    dev_byte_t        dv;

    assign dv = dev_byte_t'(shreg);

    smem_addr_ctr u_ctr (
        .clk       (clk),
        .rst       (rst),
        .load      (ctr_load),
        .load_val  (ctr_val),
        .step_page (ctr_step_page),
        .step_lin  (ctr_step_lin),
        .addr      (cur_addr)
    );

    assign rd_addr = cur_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= ST_IDLE;
            shreg         <= '0;
            txb           <= '0;
            hi_q          <= '0;
            a16_q         <= 1'b0;
            bitcnt        <= '0;
            wp_lat        <= 1'b0;
            have_data     <= 1'b0;
            mack          <= 1'b0;
            sda_pull      <= 1'b0;
            buf_we        <= 1'b0;
            buf_addr      <= '0;
            buf_data      <= '0;
            wr_commit     <= 1'b0;
            ctr_load      <= 1'b0;
            ctr_val       <= '0;
            ctr_step_page <= 1'b0;
            ctr_step_lin  <= 1'b0;
        end else begin
            buf_we        <= 1'b0;
            wr_commit     <= 1'b0;
            ctr_load      <= 1'b0;
            ctr_step_page <= 1'b0;
            ctr_step_lin  <= 1'b0;

            if (cond_start) begin
                st        <= ST_DEV;
                bitcnt    <= '0;
                sda_pull  <= 1'b0;
                have_data <= 1'b0;
                wp_lat    <= 1'b0;
            end else if (cond_stop) begin
                if (st == ST_WR && have_data) wr_commit <= 1'b1;
                st       <= ST_IDLE;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else if (st == ST_RD) begin
                if (scl_rise && bitcnt == ACK_BIT) mack <= ~sda_lvl;
                if (scl_fall) begin
                    if (bitcnt == ACK_BIT) begin
                        if (mack) begin
                            txb          <= {rd_data[BYTE_W-2:0], 1'b0};
                            sda_pull     <= ~rd_data[BYTE_W-1];
                            bitcnt       <= CNT_W'(1);
                            ctr_step_lin <= 1'b1;
                        end else begin
                            sda_pull <= 1'b0;
                            st       <= ST_SKIP;
                        end
                    end else if (bitcnt == LAST_BIT) begin
                        sda_pull <= 1'b0;
                        bitcnt   <= ACK_BIT;
                    end else begin
                        sda_pull <= ~txb[BYTE_W-1];
                        txb      <= {txb[BYTE_W-2:0], 1'b0};
                        bitcnt   <= bitcnt + CNT_W'(1);
                    end
                end
            end else if (st == ST_DEV || st == ST_AHI || st == ST_ALO || st == ST_WR) begin
                if (scl_rise && bitcnt < LAST_BIT) begin
                    shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
                    bitcnt <= bitcnt + CNT_W'(1);
                end
                if (scl_fall && bitcnt == LAST_BIT) begin
                    bitcnt <= ACK_BIT;
                    case (st)
                        ST_DEV: begin
                            if (dev_hit(dv, cs_sel) && !mem_busy) begin
                                sda_pull <= 1'b1;
                                a16_q    <= dv.top;
                                mack     <= 1'b1;
                                st       <= dv.rd ? ST_RD : ST_AHI;
                            end else begin
                                sda_pull <= 1'b0;
                                st       <= ST_SKIP;
                            end
                        end
                        ST_AHI: begin
                            hi_q     <= shreg[HI_W-1:0];
                            sda_pull <= 1'b1;
                            st       <= ST_ALO;
                        end
                        ST_ALO: begin
                            ctr_val  <= {a16_q, hi_q, shreg};
                            ctr_load <= 1'b1;
                            sda_pull <= 1'b1;
                            st       <= ST_WR;
                        end
                        default: begin
                            if (wp_lat) begin
                                sda_pull <= 1'b0;
                                st       <= ST_SKIP;
                            end else begin
                                sda_pull      <= 1'b1;
                                buf_we        <= 1'b1;
                                buf_addr      <= cur_addr;
                                buf_data      <= shreg;
                                ctr_step_page <= 1'b1;
                                have_data     <= 1'b1;
                            end
                        end
                    endcase
                end else if (scl_fall && bitcnt == ACK_BIT) begin
                    sda_pull <= 1'b0;
                    bitcnt   <= '0;
                    if (st == ST_WR && !have_data) wp_lat <= wp_in;
                end
            end
        end
    end
endmodule

// File: rtl/serial_mem_slave_chk.sv
module serial_mem_slave_chk
    import smem_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sda_pull,
    input logic             buf_we,
    input logic             wr_commit,
    input logic             mem_busy,
    input logic             cond_start,
    input logic             cond_stop,
    input logic             scl_lvl,
    input logic             scl_fall,
    input phase_e           st,
    input logic [CNT_W-1:0] bitcnt,
    input logic             wp_lat
);
    // R1
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        cond_stop |=> !sda_pull);

    // R1
    start_enter_chk: assert property (@(posedge clk) disable iff (rst)
        cond_start |=> (st == ST_DEV));

    // R3
    busy_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DEV && bitcnt == CNT_W'(BYTE_W) && scl_fall && mem_busy) |=> !sda_pull);

    // R4
    buf_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        buf_we |=> !buf_we);

    // R6
    commit_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> $past(cond_stop));

    // R7
    protect_block_chk: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> $past(!wp_lat));

    // R11
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !scl_lvl);
endmodule

bind serial_mem_slave serial_mem_slave_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sda_pull   (sda_pull),
    .buf_we     (buf_we),
    .wr_commit  (wr_commit),
    .mem_busy   (mem_busy),
    .cond_start (cond_start),
    .cond_stop  (cond_stop),
    .scl_lvl    (scl_lvl),
    .scl_fall   (scl_fall),
    .st         (st),
    .bitcnt     (bitcnt),
    .wp_lat     (wp_lat)
);

// File: tb/serial_mem_slave_test.sv
module serial_mem_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int QTR = 6;
    localparam int HI  = 8;
    localparam int BUSY_CYC = 300;
    localparam logic [1:0] CS = 2'b10;

    logic clk = 1'b0, rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
    logic sda_pull, buf_we, wr_commit;
    logic [16:0] buf_addr, rd_addr;
    logic [7:0] buf_data, rd_data;
    logic mem_busy;
    logic sda_bus;

    int checks = 0, errors = 0;
    int busy_cnt = 0, commit_cnt = 0, r11_viol = 0;
    logic prev_pull = 1'b0;
    logic [7:0] mem [int];
    int pend_a[$];
    logic [7:0] pend_d[$];
    int wlog[$];
    bit last_ack;
    logic [7:0] last_byte;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus  = sda_m & ~sda_pull;
    assign mem_busy = (busy_cnt != 0);

    serial_mem_slave uut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus), .sda_pull(sda_pull),
        .cs_sel(CS), .wp_in(wp), .mem_busy(mem_busy), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_data(buf_data), .wr_commit(wr_commit),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] mrd(int a);
        return mem.exists(a) ? mem[a] : 8'hFF;
    endfunction

    // behavioural storage: buffered bytes land at commit, then busy for a while
    always @(posedge clk) begin
        rd_data <= mrd(int'(rd_addr));
        if (rst) begin
            busy_cnt <= 0;
        end else begin
            if (buf_we) begin
                pend_a.push_back(int'(buf_addr));
                pend_d.push_back(buf_data);
                wlog.push_back(int'(buf_addr));
            end
            if (wr_commit) begin
                foreach (pend_a[k]) mem[pend_a[k]] = pend_d[k];
                pend_a.delete();
                pend_d.delete();
                commit_cnt++;
                busy_cnt <= BUSY_CYC;
            end else if (busy_cnt > 0) begin
                busy_cnt <= busy_cnt - 1;
            end
        end
        // R11 monitor: pull may only rise while the master holds SCL low
        if (!rst && sda_pull && !prev_pull && scl_m) r11_viol++;
        prev_pull <= sda_pull;
    end

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(QTR);
        scl_m = 1'b1; wt(HI);
        sda_m = 1'b0; wt(HI);
        scl_m = 1'b0; wt(QTR);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(QTR);
        scl_m = 1'b1; wt(HI);
        sda_m = 1'b1; wt(HI);
    endtask

    task automatic send_byte(logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(QTR);
            scl_m = 1'b1; wt(HI);
            scl_m = 1'b0; wt(QTR);
        end
        sda_m = 1'b1; wt(QTR);
        scl_m = 1'b1; wt(HI/2);
        last_ack = !sda_bus;
        wt(HI/2);
        scl_m = 1'b0; wt(QTR);
    endtask

    task automatic recv_byte(bit give_ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wt(QTR);
            scl_m = 1'b1; wt(HI/2);
            last_byte[i] = sda_bus;
            wt(HI/2);
            scl_m = 1'b0; wt(QTR);
        end
        sda_m = give_ack ? 1'b0 : 1'b1; wt(QTR);
        scl_m = 1'b1; wt(HI);
        scl_m = 1'b0; wt(QTR);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dev(logic a16, logic rd);
        return {4'b1010, CS, a16, rd};
    endfunction

    // write header: START, slave address (write), two address bytes
    task automatic hdr(int addr);
        bus_start();
        send_byte(dev(addr[16], 1'b0));
        chk("R2 header ack", int'(last_ack), 1);
        send_byte(addr[15:8]);
        chk("R4 high address ack", int'(last_ack), 1);
        send_byte(addr[7:0]);
        chk("R4 low address ack", int'(last_ack), 1);
    endtask

    task automatic wait_ready();
        wt(2);
        while (mem_busy) wt(1);
        wt(10);
    endtask

    initial begin
        int c0, w0;
        wt(5);
        rst = 1'b0;
        wt(5);
        // reset state
        chk("R1 reset pull", int'(sda_pull), 0);
        chk("R6 reset commit", int'(wr_commit), 0);
        chk("R4 reset buf_we", int'(buf_we), 0);

        // R2 select mismatch and code mismatch are refused
        bus_start(); send_byte({4'b1010, 2'b01, 1'b0, 1'b0});
        chk("R2 wrong select nack", int'(last_ack), 0); bus_stop();
        bus_start(); send_byte({4'b1011, CS, 1'b0, 1'b0});
        chk("R2 wrong code nack", int'(last_ack), 0); bus_stop();

        // R4 R5 page write across the page end
        hdr(17'h123FE);
        send_byte(8'hA1); chk("R4 data0 ack", int'(last_ack), 1);
        send_byte(8'hB2); chk("R4 data1 ack", int'(last_ack), 1);
        send_byte(8'hC3); chk("R4 data2 ack", int'(last_ack), 1);
        bus_stop();
        wt(2);
        chk("R6 one commit", commit_cnt, 1);
        chk("R4 buffered count", wlog.size(), 3);
        chk("R4 first address", wlog[0], 32'h123FE);
        chk("R5 page wrap address", wlog[2], 32'h12300);

        // R3 polling during busy
        bus_start(); send_byte(dev(1'b0, 1'b1));
        chk("R3 busy nack", int'(last_ack), 0); bus_stop();
        wait_ready();
        bus_start(); send_byte(dev(1'b0, 1'b1));
        chk("R3 ready ack", int'(last_ack), 1);
        recv_byte(1'b0);
        chk("R9 counter after write", int'(last_byte), 8'hFF);
        bus_stop();

        // R10 R8 R9 selective sequential read over the page end
        c0 = commit_cnt;
        hdr(17'h123FE);
        bus_start(); send_byte(dev(1'b1, 1'b1));
        chk("R10 read header ack", int'(last_ack), 1);
        recv_byte(1'b1); chk("R8 byte0", int'(last_byte), 8'hA1);
        recv_byte(1'b1); chk("R8 byte1", int'(last_byte), 8'hB2);
        recv_byte(1'b0); chk("R9 linear across page", int'(last_byte), 8'hFF);
        bus_stop();
        wt(3);
        chk("R8 released after noack", int'(sda_pull), 0);
        chk("R10 no commit on dummy write", commit_cnt, c0);
        hdr(17'h12300);
        bus_start(); send_byte(dev(1'b1, 1'b1));
        recv_byte(1'b0); chk("R5 wrapped byte", int'(last_byte), 8'hC3);
        bus_stop();

        // R9 full wrap of the counter
        hdr(17'h00000); send_byte(8'h5A); send_byte(8'h96); bus_stop(); wait_ready();
        hdr(17'h1FFFF); send_byte(8'h3C); bus_stop(); wait_ready();
        hdr(17'h1FFFF);
        bus_start(); send_byte(dev(1'b1, 1'b1));
        recv_byte(1'b1); chk("R9 top byte", int'(last_byte), 8'h3C);
        recv_byte(1'b0); chk("R9 wrap to zero", int'(last_byte), 8'h5A);
        bus_stop();
        bus_start(); send_byte(dev(1'b0, 1'b1));
        recv_byte(1'b0); chk("R9 current address", int'(last_byte), 8'h96);
        bus_stop();

        // R7 write protect
        c0 = commit_cnt; w0 = wlog.size();
        wp = 1'b1;
        hdr(17'h00010);
        send_byte(8'h77); chk("R7 protected data nack", int'(last_ack), 0);
        bus_stop();
        wt(3);
        wp = 1'b0;
        chk("R7 no commit", commit_cnt, c0);
        chk("R7 nothing buffered", wlog.size(), w0);
        hdr(17'h00010);
        bus_start(); send_byte(dev(1'b0, 1'b1));
        recv_byte(1'b0); chk("R7 memory untouched", int'(last_byte), 8'hFF);
        bus_stop();

        // R1 STOP releases and R11 pull timing
        wt(3);
        chk("R1 idle after stop", int'(sda_pull), 0);
        chk("R11 pull only with SCL low", r11_viol, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule